// File: doc/BRIEF.md
# Byte-Parallel LFSR Pattern Generator

This block holds an 8-bit pseudo-random state and produces a fresh pattern byte on every rising clock edge. The underlying sequence is a single-bit Fibonacci shift register. Each step moves every bit one place toward the MSB and feeds a new bit 0 from the XOR of bits 7, 3, 2 and 1. The block does not run one such step per clock. It collapses eight of them into one combinational update, so a whole byte of the serial stream appears at once.

A single-cycle load strobe seeds the register from a parallel input. A transmitter and a receiver can each hold one copy of this block. When both start from the same seed, they produce identical byte streams.

Top module: `lfsr_byte_gen`

## Requirements
- R1: While reset is asserted, `pattern` reads 8'h01, and it keeps that value until the first clock edge after reset is released.
- R2: On a clock edge where `load` is high, `pattern` takes the value of `load_data`. The load wins over the advance, including on back-to-back load cycles.
- R3: On a clock edge where `load` is low, `pattern` becomes the result of eight serial steps applied to its previous value. One serial step is {s[6:0], s[7]^s[3]^s[2]^s[1]}.
- R4: The advance equals these per-bit equations, where n is the next value and s the present one:
  - n7=s1^s2^s3^s7
  - n6=s0^s1^s2^s6
  - n5=s0^s2^s3^s5^s7
  - n4=s3^s4^s6^s7
  - n3=s2^s3^s5^s6
  - n2=s1^s2^s4^s5
  - n1=s0^s1^s3^s4
  - n0=s0^s1^s7
- R5: Advancing from a nonzero value never produces 8'h00.
- R6: Once 8'h00 is loaded, advancing keeps `pattern` at 8'h00.
- R7: Starting from 8'h01, the first return to 8'h01 comes after exactly 255 advancing clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset to seed 8'h01 |
| load | input | 1 | Seed strobe; loads `load_data` instead of advancing |
| load_data | input | 8 | Parallel seed value |
| pattern | output | 8 | Current pattern byte |

## Verification
The main run advances 300 clocks from the reset seed. Every byte is compared against a bit-serial model that steps eight times, and also against the per-bit equations, so an error in the unrolling is separated from an error in the tap choice. Separate runs start from seeds of mixed, all-ones and MSB-only values, which exercise tap bit 7 in each of its states. Back-to-back loads show whether the load really takes priority. A zero seed exposes any feedback inversion, because a wrong design would not stay at zero. The full 255-clock cycle from 8'h01 shows whether the sequence is maximal or repeats early.

// File: rtl/lfsr_byte_gen.sv
module lfsr_byte_gen #(
  parameter int WIDTH = 8,
  parameter int STEPS = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'h8E,
  parameter logic [WIDTH-1:0] SEED = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  output logic [WIDTH-1:0] pattern
);

  function automatic logic [WIDTH-1:0] leap(input logic [WIDTH-1:0] s);
    logic [WIDTH-1:0] v;
    v = s;
    for (int k = 0; k < STEPS; k++)
      v = {v[WIDTH-2:0], ^(v & TAPS)};
    return v;
  endfunction

  logic [WIDTH-1:0] state;
  logic [WIDTH-1:0] state_nxt;

  assign state_nxt = load ? load_data : leap(state);
  assign pattern   = state;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEED;
    else        state <= state_nxt;
  end

endmodule

// File: rtl/lfsr_byte_gen_chk.sv
module lfsr_byte_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load,
  input logic [7:0] load_data,
  input logic [7:0] pattern
);

  function automatic logic [7:0] eq8(input logic [7:0] s);
    logic [7:0] n;
    n[7] = s[1]^s[2]^s[3]^s[7];
    n[6] = s[0]^s[1]^s[2]^s[6];
    n[5] = s[0]^s[2]^s[3]^s[5]^s[7];
    n[4] = s[3]^s[4]^s[6]^s[7];
    n[3] = s[2]^s[3]^s[5]^s[6];
    n[2] = s[1]^s[2]^s[4]^s[5];
    n[1] = s[0]^s[1]^s[3]^s[4];
    n[0] = s[0]^s[1]^s[7];
    return n;
  endfunction

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pattern == $past(load_data)); // R2

  AST_ADVANCE_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> pattern == eq8($past(pattern))); // R4

  AST_NO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && pattern != 8'h00) |=> pattern != 8'h00); // R5

  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && pattern == 8'h00) |=> pattern == 8'h00); // R6

endmodule

bind lfsr_byte_gen lfsr_byte_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data), .pattern(pattern)
);

// File: tb/lfsr_byte_gen_test.sv
module lfsr_byte_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [7:0] load_data = 8'h00;
  logic [7:0] pattern;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] q_ser[$];
  logic [7:0] q_eq[$];
  logic [7:0] q_prev[$];
  bit         q_ld[$];

  logic [7:0] model = 8'h01;
  int adv_since_seed = 0;
  int first_return = 0;
  bit tracking = 1'b0;

  always #2.5 clk = ~clk;

  lfsr_byte_gen uut (.clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data), .pattern(pattern));

  function automatic logic [7:0] serial8(input logic [7:0] s);
    logic [7:0] v = s;
    for (int k = 0; k < 8; k++) v = {v[6:0], v[7]^v[3]^v[2]^v[1]};
    return v;
  endfunction

  function automatic logic [7:0] eqs(input logic [7:0] s);
    return {s[1]^s[2]^s[3]^s[7], s[0]^s[1]^s[2]^s[6], s[0]^s[2]^s[3]^s[5]^s[7],
            s[3]^s[4]^s[6]^s[7], s[2]^s[3]^s[5]^s[6], s[1]^s[2]^s[4]^s[5],
            s[0]^s[1]^s[3]^s[4], s[0]^s[1]^s[7]};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic drive(input bit ld, input logic [7:0] d);
    load = ld;
    load_data = d;
    q_prev.push_back(model);
    q_ld.push_back(ld);
    if (ld) begin
      q_ser.push_back(d);
      q_eq.push_back(d);
      model = d;
    end else begin
      q_ser.push_back(serial8(model));
      q_eq.push_back(eqs(model));
      model = serial8(model);
    end
    @(negedge clk);
  endtask

  task automatic advance(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 8'h00);
  endtask

  always @(posedge clk) begin
    #1;
    if (q_ser.size() != 0) begin
      logic [7:0] es, ee, pv;
      bit ld;
      es = q_ser.pop_front();
      ee = q_eq.pop_front();
      pv = q_prev.pop_front();
      ld = q_ld.pop_front();
      if (ld) begin
        check("R2", pattern, es);
        tracking = (es == 8'h01);
        adv_since_seed = 0;
      end else begin
        check("R3", pattern, es);
        check("R4", pattern, ee);
        if (pv != 8'h00) begin
          checks++;
          if (pattern == 8'h00) begin
            errors++;
            $display("FAIL R5: actual %02h expected nonzero from %02h", pattern, pv);
          end
        end else check("R6", pattern, 8'h00);
        if (tracking) begin
          adv_since_seed++;
          if (pattern == 8'h01) begin
            first_return = adv_since_seed;
            tracking = 1'b0;
          end
        end
      end
    end
  end

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", pattern, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", pattern, 8'h01);
    advance(300);
    drive(1'b1, 8'hA5); advance(20);
    drive(1'b1, 8'hFF); advance(10);
    drive(1'b1, 8'h80); advance(10);
    drive(1'b1, 8'h3C); drive(1'b1, 8'hC3); advance(4);
    drive(1'b1, 8'h00); advance(5);
    drive(1'b1, 8'h01); advance(255);
    load = 1'b0;
    @(negedge clk);
    check("R7", 8'(first_return), 8'd255);
    done = 1'b1;
    finish_run();
  end
endmodule